// File: doc/BRIEF.md
# Transmit Descriptor Ring Manager

This block keeps a small ring of transmit descriptors in a shared descriptor memory. A send request carries a packet length. The block fills the next free slot with the slot's buffer address, an encoded length and a set of flags, and hands the slot to the transmit controller by setting its owner bit. The controller is a separate agent. It reaches the same memory through a word-wide access port. When it has sent a frame, it clears the owner bit and may set an error flag and status bits.

A completion event starts a walk over the ring. The walk begins at the oldest outstanding slot and reclaims one slot per cycle. It stops at the first slot the controller still owns, or when nothing is outstanding. A reclaimed slot is counted as good or as errored. An errored slot is given to exactly one cause by a fixed priority, and an underflow also asks for a controller reinitialisation. When the walk ends, the block pulses a write-one-to-clear for the transmit interrupt and drops the queue-full flag. The block pulses transmit-demand when a descriptor is posted to an empty ring. A request that finds every slot in use is dropped and counted.

Top module: `txd_ring_mgr`

## Requirements
- R1: After reset all counters are zero, `q_full`, `tx_demand`, `int_clr` and `reinit_req` are low, and every descriptor word reads 0.
- R2: Slot s occupies words 4s..4s+3. An accepted request writes the slot's words in this order: word 0 = BUF_BASE + s*BUF_SIZE (defaults 0x0040 and 0x0600), word 1 = flags 0x8003 (owner bit 15, start bit 1, end bit 0, error bit 14 clear), word 3 = 0.
- R3: Word 2 holds the two's complement of the length after it is raised to at least 60, taken modulo 65536 (0 and 59 give 0xFFC4, 61 gives 0xFFC3, 1514 gives 0xFA16).
- R4: Requests take slots 0, 1, 2, 3 in turn and then wrap to slot 0. Completion walks slots in the same order and wraps the same way.
- R5: `tx_demand` is high for exactly one cycle after a request is accepted while no slot was outstanding. Requests accepted while slots are outstanding give no pulse.
- R6: `q_full` rises when the fourth slot becomes outstanding. A request made while all four slots are outstanding writes no descriptor word and adds 1 to `drop_cnt`, even when `q_full` has already been released.
- R7: After `cmp_evt`, the walk examines one slot per cycle starting at the oldest outstanding slot. It stops at a slot whose owner bit is set, or when no slot is outstanding. Each reclaimed slot frees one place in the ring.
- R8: A reclaimed slot whose error flag (bit 14 of word 1) is clear adds 1 to `good_cnt`.
- R9: A reclaimed slot with its error flag set adds 1 to `err_cnt` and at most one cause counter, chosen from status word 3 by priority: underflow bit 3, then late collision bit 2, then loss of carrier bit 1, then retry exhaustion bit 0.
- R10: An underflow classification produces a one-cycle `reinit_req` pulse.
- R11: When the walk ends, `int_clr` pulses for one cycle and `q_full` is cleared, even if no slot was reclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Send request this cycle |
| req_len | input | 16 | Packet length in bytes |
| cmp_evt | input | 1 | Transmit-complete event, starts a walk |
| ctl_addr | input | 4 | Controller word address into descriptor memory |
| ctl_we | input | 1 | Controller word write enable |
| ctl_wdata | input | 16 | Controller write data |
| ctl_rdata | output | 16 | Word at `ctl_addr` |
| q_full | output | 1 | Queue-full flag |
| tx_demand | output | 1 | Transmit-demand pulse |
| int_clr | output | 1 | Write-one-to-clear pulse for the transmit interrupt |
| reinit_req | output | 1 | Controller reinitialisation request pulse |
| good_cnt | output | 16 | Frames sent without error |
| err_cnt | output | 16 | Frames sent with error |
| uflo_cnt | output | 16 | Underflow errors |
| lcol_cnt | output | 16 | Late collision errors |
| lcar_cnt | output | 16 | Loss-of-carrier errors |
| rtry_cnt | output | 16 | Retry-exhaustion errors |
| drop_cnt | output | 16 | Requests dropped on a full ring |

## Verification
A table of eight lengths is posted one at a time into an empty ring. Each is completed cleanly. This separates padding of short frames from pass-through of long ones, checks that each post lands in the right slot across a full wrap, and shows a demand pulse on every post. A directed sequence then fills the ring and drops an extra request. The controller completes only the first slots, with several status bits set together, so the priority order decides which cause is counted. A walk that finds the head slot still owned shows that the full flag is released while the ring stays full, and the next request is still dropped.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W = 16;
  localparam int DESC_WORDS = 4;

  // word positions inside a descriptor
  localparam int W_BUF   = 0;
  localparam int W_FLAGS = 1;
  localparam int W_LEN   = 2;
  localparam int W_STAT  = 3;

  // flags word bits
  localparam int F_OWN = 15;
  localparam int F_ERR = 14;
  localparam int F_STP = 1;
  localparam int F_ENP = 0;

  // status word bits, also the order of the class vector
  localparam int S_UFLO = 3;
  localparam int S_LCOL = 2;
  localparam int S_LCAR = 1;
  localparam int S_RTRY = 0;

  // counter slots
  localparam int C_GOOD = 0;
  localparam int C_ERR  = 1;
  localparam int C_UFLO = 2;
  localparam int C_LCOL = 3;
  localparam int C_LCAR = 4;
  localparam int C_RTRY = 5;
  localparam int C_DROP = 6;
  localparam int NUM_CNT = 7;

  typedef logic [DESC_WORDS-1:0][WORD_W-1:0] desc_t;

  // encoded length: padded length negated modulo 2^16
  function automatic logic [WORD_W-1:0] len_code(input logic [WORD_W-1:0] len,
                                                 input int unsigned min_len);
    logic [WORD_W-1:0] padded;
    padded = (len < WORD_W'(min_len)) ? WORD_W'(min_len) : len;
    return WORD_W'(0) - padded;
  endfunction

  // one-hot cause from status bits by fixed priority
  function automatic logic [3:0] classify(input logic [3:0] st);
    logic [3:0] c;
    c = '0;
    if (st[S_UFLO])      c[S_UFLO] = 1'b1;
    else if (st[S_LCOL]) c[S_LCOL] = 1'b1;
    else if (st[S_LCAR]) c[S_LCAR] = 1'b1;
    else if (st[S_RTRY]) c[S_RTRY] = 1'b1;
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] flags_new();
    logic [WORD_W-1:0] f;
    f = '0;
    f[F_OWN] = 1'b1;
    f[F_STP] = 1'b1;
    f[F_ENP] = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/txd_desc_ram.sv
module txd_desc_ram
  import txd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(DEPTH)-1:0]      wr_slot,
  input  desc_t                         wr_desc,
  input  logic                          ctl_we,
  input  logic [$clog2(DEPTH*4)-1:0]    ctl_addr,
  input  logic [WORD_W-1:0]             ctl_wdata,
  output logic [WORD_W-1:0]             ctl_rdata,
  input  logic [$clog2(DEPTH)-1:0]      look_slot,
  output logic [WORD_W-1:0]             look_flags,
  output logic [WORD_W-1:0]             look_stat
);
  localparam int NWORDS = DEPTH * DESC_WORDS;
  localparam int AW = $clog2(NWORDS);
  localparam int SW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem_q [NWORDS];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam int SLOT = i / DESC_WORDS;
    localparam int FLD  = i % DESC_WORDS;
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[i] <= '0;
      else if (wr_en && wr_slot == SW'(SLOT))
        mem_q[i] <= wr_desc[FLD];
      else if (ctl_we && ctl_addr == AW'(i))
        mem_q[i] <= ctl_wdata;
    end
  end

  assign ctl_rdata  = mem_q[ctl_addr];
  assign look_flags = mem_q[{look_slot, 2'(W_FLAGS)}];
  assign look_stat  = mem_q[{look_slot, 2'(W_STAT)}];
endmodule

// File: rtl/txd_ring_ptrs.sv
module txd_ring_ptrs #(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  output logic [$clog2(DEPTH)-1:0]     put_idx,
  output logic [$clog2(DEPTH)-1:0]     done_idx,
  output logic [$clog2(DEPTH+1)-1:0]   busy
);
  localparam int SW = $clog2(DEPTH);

  function automatic logic [SW-1:0] step(input logic [SW-1:0] idx);
    return (idx == SW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      put_idx  <= '0;
      done_idx <= '0;
      busy     <= '0;
    end else begin
      if (push) put_idx  <= step(put_idx);
      if (pop)  done_idx <= step(done_idx);
      case ({push, pop})
        2'b10:   busy <= busy + 1'b1;
        2'b01:   busy <= busy - 1'b1;
        default: busy <= busy;
      endcase
    end
  end
endmodule

// File: rtl/txd_reclaim.sv
module txd_reclaim
  import txd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [$clog2(DEPTH+1)-1:0]  busy,
  input  logic [WORD_W-1:0]           flags,
  input  logic [WORD_W-1:0]           stat,
  output logic                        walking,
  output logic                        pop,
  output logic                        fin,
  output logic                        good_ev,
  output logic                        err_ev,
  output logic [3:0]                  cls_ev,
  output logic                        int_clr,
  output logic                        reinit_req
);
  logic empty, owned;

  assign empty   = (busy == '0);
  assign owned   = flags[F_OWN];
  assign fin     = walking && (empty || owned);
  assign pop     = walking && !empty && !owned;
  assign good_ev = pop && !flags[F_ERR];
  assign err_ev  = pop && flags[F_ERR];
  assign cls_ev  = err_ev ? classify(stat[3:0]) : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walking    <= 1'b0;
      int_clr    <= 1'b0;
      reinit_req <= 1'b0;
    end else begin
      walking    <= walking ? !fin : start;
      int_clr    <= fin;
      reinit_req <= cls_ev[S_UFLO];
    end
  end
endmodule

// File: rtl/txd_ring_mgr.sv
module txd_ring_mgr
  import txd_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int MIN_LEN  = 60,
  parameter int BUF_BASE = 'h0040,
  parameter int BUF_SIZE = 'h0600,
  parameter int CNT_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [15:0]                 req_len,
  input  logic                        cmp_evt,
  input  logic [$clog2(DEPTH*4)-1:0]  ctl_addr,
  input  logic                        ctl_we,
  input  logic [15:0]                 ctl_wdata,
  output logic [15:0]                 ctl_rdata,
  output logic                        q_full,
  output logic                        tx_demand,
  output logic                        int_clr,
  output logic                        reinit_req,
  output logic [CNT_W-1:0]            good_cnt,
  output logic [CNT_W-1:0]            err_cnt,
  output logic [CNT_W-1:0]            uflo_cnt,
  output logic [CNT_W-1:0]            lcol_cnt,
  output logic [CNT_W-1:0]            lcar_cnt,
  output logic [CNT_W-1:0]            rtry_cnt,
  output logic [CNT_W-1:0]            drop_cnt
);
  localparam int SW = $clog2(DEPTH);
  localparam int BW = $clog2(DEPTH + 1);

  // named internal events, observed by the bound checker
  logic [SW-1:0]     put_w, done_w;
  logic [BW-1:0]     busy_w;
  logic              push_w, pop_w, drop_w, walk_w, fin_w;
  logic              good_w, err_w;
  logic [3:0]        cls_w;
  logic [WORD_W-1:0] look_flags, look_stat;
  desc_t             new_desc;

  assign push_w = req_valid && (busy_w != BW'(DEPTH));
  assign drop_w = req_valid && (busy_w == BW'(DEPTH));

  always_comb begin
    new_desc         = '0;
    new_desc[W_BUF]  = WORD_W'(BUF_BASE + int'(put_w) * BUF_SIZE);
    new_desc[W_FLAGS] = flags_new();
    new_desc[W_LEN]  = len_code(req_len, MIN_LEN);
    new_desc[W_STAT] = '0;
  end

  txd_ring_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w),
    .put_idx(put_w), .done_idx(done_w), .busy(busy_w)
  );

  txd_desc_ram #(.DEPTH(DEPTH)) ram_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_w), .wr_slot(put_w), .wr_desc(new_desc),
    .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata),
    .look_slot(done_w), .look_flags(look_flags), .look_stat(look_stat)
  );

  txd_reclaim #(.DEPTH(DEPTH)) walk_i (
    .clk(clk), .rst_n(rst_n), .start(cmp_evt), .busy(busy_w),
    .flags(look_flags), .stat(look_stat),
    .walking(walk_w), .pop(pop_w), .fin(fin_w),
    .good_ev(good_w), .err_ev(err_w), .cls_ev(cls_w),
    .int_clr(int_clr), .reinit_req(reinit_req)
  );

  // demand pulse and full flag
  logic dem_q, full_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dem_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      dem_q <= push_w && (busy_w == '0);
      if (push_w && !pop_w && busy_w == BW'(DEPTH - 1)) full_q <= 1'b1;
      else if (fin_w)                                   full_q <= 1'b0;
    end
  end
  assign tx_demand = dem_q;
  assign q_full    = full_q;

  // event counters
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];

  always_comb begin
    inc         = '0;
    inc[C_GOOD] = good_w;
    inc[C_ERR]  = err_w;
    inc[C_UFLO] = cls_w[S_UFLO];
    inc[C_LCOL] = cls_w[S_LCOL];
    inc[C_LCAR] = cls_w[S_LCAR];
    inc[C_RTRY] = cls_w[S_RTRY];
    inc[C_DROP] = drop_w;
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q[k] <= '0;
      else if (inc[k]) cnt_q[k] <= cnt_q[k] + 1'b1;
    end
  end

  assign good_cnt = cnt_q[C_GOOD];
  assign err_cnt  = cnt_q[C_ERR];
  assign uflo_cnt = cnt_q[C_UFLO];
  assign lcol_cnt = cnt_q[C_LCOL];
  assign lcar_cnt = cnt_q[C_LCAR];
  assign rtry_cnt = cnt_q[C_RTRY];
  assign drop_cnt = cnt_q[C_DROP];
endmodule

// File: rtl/txd_ring_chk.sv
module txd_ring_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [$clog2(DEPTH)-1:0]    put_w,
  input logic [$clog2(DEPTH+1)-1:0]  busy_w,
  input logic                        push_w,
  input logic                        pop_w,
  input logic                        drop_w,
  input logic                        walk_w,
  input logic                        err_w,
  input logic [3:0]                  cls_w,
  input logic                        tx_demand,
  input logic                        int_clr,
  input logic                        reinit_req,
  input logic [CNT_W-1:0]            drop_cnt
);
  // R6
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(busy_w) <= DEPTH);

  // R7
  busy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_w || pop_w) |=> int'(busy_w) ==
      int'($past(busy_w)) + int'($past(push_w)) - int'($past(pop_w)));

  // R5
  demand_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_demand |-> $past(push_w) && $past(busy_w) == '0);

  // R6
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> put_w == $past(put_w) && drop_cnt == $past(drop_cnt) + 1'b1);

  // R9
  one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cls_w) && ((cls_w != 4'b0000) -> err_w));

  // R10
  reinit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |-> $past(cls_w[3]));

  // R11
  clr_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr |-> $past(walk_w) && !walk_w);
endmodule

bind txd_ring_mgr txd_ring_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .put_w(put_w), .busy_w(busy_w),
  .push_w(push_w), .pop_w(pop_w), .drop_w(drop_w), .walk_w(walk_w),
  .err_w(err_w), .cls_w(cls_w), .tx_demand(tx_demand), .int_clr(int_clr),
  .reinit_req(reinit_req), .drop_cnt(drop_cnt)
);

// File: tb/txd_ring_mgr_tb.sv
module txd_ring_mgr_tb_top;
  localparam int BASE = 'h0040;
  localparam int BSZ  = 'h0600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_len = '0;
  logic cmp_evt = 1'b0;
  logic [3:0] ctl_addr = '0;
  logic ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic q_full, tx_demand, int_clr, reinit_req;
  logic [15:0] good_cnt, err_cnt, uflo_cnt, lcol_cnt, lcar_cnt, rtry_cnt, drop_cnt;

  int checks = 0;
  int errors = 0;
  int dem_seen = 0;
  int clr_seen = 0;
  int reinit_seen = 0;

  always #4 clk = ~clk;

  txd_ring_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .cmp_evt(cmp_evt), .ctl_addr(ctl_addr), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .q_full(q_full),
    .tx_demand(tx_demand), .int_clr(int_clr), .reinit_req(reinit_req),
    .good_cnt(good_cnt), .err_cnt(err_cnt), .uflo_cnt(uflo_cnt),
    .lcol_cnt(lcol_cnt), .lcar_cnt(lcar_cnt), .rtry_cnt(rtry_cnt),
    .drop_cnt(drop_cnt)
  );

  always @(posedge clk) begin
    if (rst_n && tx_demand)  dem_seen++;
    if (rst_n && int_clr)    clr_seen++;
    if (rst_n && reinit_req) reinit_seen++;
  end

  // {length, expected code}
  localparam logic [31:0] VEC [8] = '{
    {16'd0,    16'hFFC4}, {16'd59,  16'hFFC4}, {16'd60,  16'hFFC4},
    {16'd61,   16'hFFC3}, {16'd1514,16'hFA16}, {16'd64,  16'hFFC0},
    {16'd1,    16'hFFC4}, {16'd1000,16'hFC18}
  };

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int addr, output logic [15:0] v);
    ctl_addr = 4'(addr);
    #1 v = ctl_rdata;
  endtask

  task automatic wr(input int addr, input logic [15:0] v);
    @(negedge clk);
    ctl_addr = 4'(addr); ctl_wdata = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic send(input logic [15:0] len);
    @(negedge clk);
    req_valid = 1'b1; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic walk();
    int n;
    int c0;
    c0 = clr_seen;
    @(negedge clk);
    cmp_evt = 1'b1;
    @(negedge clk);
    cmp_evt = 1'b0;
    n = 0;
    while (clr_seen == c0 && n < 20) begin
      @(negedge clk);
      n++;
    end
    check("R11", "walk ended with int_clr", clr_seen - c0, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, v);
      check("R1", "descriptor word after reset", v, 0);
    end
    check("R1", "q_full", q_full, 0);
    check("R1", "tx_demand", tx_demand, 0);
    check("R1", "counters", good_cnt | err_cnt | drop_cnt | uflo_cnt, 0);

    // table: one frame at a time through an empty ring
    for (int i = 0; i < 8; i++) begin
      int s;
      s = i % 4;
      send(VEC[i][31:16]);
      rd(4*s + 1, v); check("R2", "flags word", v, 16'h8003);
      rd(4*s + 0, v); check("R2", "buffer word", v, BASE + s*BSZ);
      rd(4*s + 3, v); check("R2", "status word", v, 0);
      rd(4*s + 2, v); check("R3", "length code", v, VEC[i][15:0]);
      wr(4*s + 1, 16'h0003);
      walk();
      check("R8", "good_cnt", good_cnt, i + 1);
      check("R5", "demand pulses", dem_seen, i + 1);
      check("R4", "slot used in turn", s, i % 4);
    end
    check("R9", "no errors from clean frames", err_cnt, 0);

    // fill the ring
    send(16'd100); send(16'd200); send(16'd300);
    check("R6", "q_full before fourth", q_full, 0);
    send(16'd400);
    check("R6", "q_full after fourth", q_full, 1);
    check("R5", "no demand on non-empty ring", dem_seen, 9);
    send(16'd500);
    check("R6", "drop_cnt", drop_cnt, 1);
    rd(2, v); check("R6", "slot 0 length untouched by drop", v, 16'hFF9C);

    // controller completes slots 0 and 1 with errors, slot 2 still owned
    wr(3, 16'h000C); wr(1, 16'h4003);
    wr(7, 16'h0003); wr(5, 16'h4003);
    walk();
    check("R9", "err_cnt", err_cnt, 2);
    check("R9", "underflow wins over late collision", uflo_cnt, 1);
    check("R9", "late collision not counted", lcol_cnt, 0);
    check("R9", "carrier wins over retry", lcar_cnt, 1);
    check("R9", "retry not counted", rtry_cnt, 0);
    check("R10", "reinit pulses", reinit_seen, 1);
    check("R7", "walk stops at owned slot", good_cnt, 8);
    check("R11", "q_full released", q_full, 0);

    // two more posts wrap into slots 0 and 1
    send(16'd700);
    rd(2, v); check("R4", "put wrapped to slot 0", v, 16'hFD44);
    send(16'd800);
    check("R5", "no demand with slots outstanding", dem_seen, 9);
    check("R6", "q_full again", q_full, 1);

    // walk with head still owned
    walk();
    check("R11", "q_full released with nothing reclaimed", q_full, 0);
    check("R7", "nothing reclaimed", good_cnt + err_cnt, 10);
    send(16'd900);
    check("R6", "still dropped when flag released", drop_cnt, 2);
    rd(10, v); check("R6", "slot 2 length untouched", v, 16'hFED4);

    // complete everything, walk across the wrap
    wr(11, 16'h0001); wr(9, 16'h4003);
    wr(15, 16'h0006); wr(13, 16'h4003);
    wr(1, 16'h0003);  wr(5, 16'h0003);
    walk();
    check("R9", "err_cnt total", err_cnt, 4);
    check("R9", "retry only", rtry_cnt, 1);
    check("R9", "late collision over carrier", lcol_cnt, 1);
    check("R9", "carrier unchanged", lcar_cnt, 1);
    check("R8", "good_cnt total", good_cnt, 10);
    check("R10", "no extra reinit", reinit_seen, 1);

    // ring empty again: demand returns, post lands in slot 2
    send(16'd50);
    @(negedge clk);
    check("R5", "demand after drain", dem_seen, 10);
    rd(10, v); check("R7", "next slot after wrap walk", v, 16'hFFC4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule